// File: doc/BRIEF.md
# Variable-Length Vector Byte Mover

This block moves between 0 and 16 bytes between byte-wide memory and a 128-bit vector register, one byte per memory access. A single start pulse carries the whole operation: a direction (load or store), a starting address, a 64-bit length operand whose top byte gives the byte count, the vector register contents for a store, and two placement controls. One control selects little-endian placement and the other selects the left-justified variant.

For a load, the vector image starts at all zeros. Each returned byte goes into its lane, and the finished 128-bit value is written out once with a done pulse. For a store, the same lane order chooses which vector byte goes to each successive address. Vector byte 0 is the most significant byte, bits 127:120. Lane k covers bits 127-8k down to 120-8k. Memory accesses use a request/acknowledge handshake with one access outstanding at a time. Address translation and faults are handled elsewhere.

Top module: `vxl_mover`

## Requirements
- R1: The byte count is bits 63:56 of `len_op`; bits 55:0 have no effect on any transfer.
- R2: A count field of 16 or more is treated as exactly 16 byte accesses.
- R3: On a load, vector lanes not reached by the count read as zero in `vec_out`, whatever the previous result held.
- R4: A count of zero performs no memory access; a load then returns an all-zero `vec_out` with `vec_we` and `done`, and a store only pulses `done`.
- R5: With `le_mode`=1 and `left_just`=0, the i-th accessed byte (i from 0) maps to vector lane 15-i.
- R6: In every other mode combination, the i-th accessed byte maps to vector lane i.
- R7: The i-th access uses address `addr_in`+i modulo 2^32.
- R8: On a load, `vec_we` pulses exactly once, in the same cycle as `done`, after the last byte is acknowledged; stores never raise `vec_we`.
- R9: `mem_req` stays high with stable `mem_addr`, `mem_we` and `mem_wdata` until `mem_ack` is sampled high; each ack completes one access.
- R10: A store writes only the counted bytes, taking each from `vec_in` at its mapped lane, with `mem_we`=1.
- R11: A `start` pulse while `busy` is high is ignored and does not change the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| is_store | input | 1 | 1 = store vector bytes to memory, 0 = load |
| le_mode | input | 1 | Little-endian placement mode |
| left_just | input | 1 | Left-justified variant (forces upward lane order) |
| addr_in | input | 32 | Address of the first byte |
| len_op | input | 64 | Length operand; count in bits 63:56 |
| vec_in | input | 128 | Vector register contents for a store |
| mem_req | output | 1 | Byte access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Access accepted or completed |
| mem_rdata | input | 8 | Read byte, valid with `mem_ack` |
| vec_out | output | 128 | Assembled load result |
| vec_we | output | 1 | Write strobe for `vec_out` |
| done | output | 1 | Operation finished (one cycle) |
| busy | output | 1 | Operation in progress |

## Verification
The hardest conditions to reach are a stray `start` that arrives in the middle of a slow load, and an address run that crosses the 2^32 boundary while the memory stalls between acknowledges. The bench memory model inserts a programmable number of idle cycles before each acknowledge. One directed test raises a second `start`, with the opposite direction and a full-length count, while a delayed load is still collecting bytes. The table also includes operations that start a few bytes below the top of the address space. The model compares each accessed address with an independently tracked expected address, so a carry into the upper bits or a missed wrap is reported.

// File: rtl/vxl_pkg.sv
package vxl_pkg;

    localparam int VXL_LANES   = 16;
    localparam int VXL_BYTE_W  = 8;
    localparam int VXL_VEC_W   = VXL_LANES * VXL_BYTE_W;
    localparam int VXL_LANE_W  = $clog2(VXL_LANES);
    localparam int VXL_CNT_W   = $clog2(VXL_LANES + 1);
    localparam int VXL_LEN_W   = 64;
    localparam int VXL_FLD_LSB = 56;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_FIN  = 2'd2
    } vxl_state_e;

    typedef struct packed {
        logic                 store;
        logic                 reverse;
        logic [VXL_CNT_W-1:0] count;
    } vxl_op_t;

    // Saturate the raw 8-bit length field at the lane count.
    function automatic logic [VXL_CNT_W-1:0] vxl_clamp(input logic [7:0] raw);
        if (raw >= 8'(VXL_LANES)) return VXL_CNT_W'(VXL_LANES);
        return VXL_CNT_W'(raw);
    endfunction

    // Lane for the step-th byte: upward, or downward from the last lane.
    function automatic logic [VXL_LANE_W-1:0] vxl_lane(input logic [VXL_LANE_W-1:0] step,
                                                       input logic reverse);
        if (reverse) return VXL_LANE_W'(VXL_LANES - 1) - step;
        return step;
    endfunction

endpackage

// File: rtl/vxl_len_decode.sv
module vxl_len_decode
    import vxl_pkg::*;
#(
    parameter int LEN_W   = VXL_LEN_W,
    parameter int FLD_LSB = VXL_FLD_LSB,
    parameter int CNT_W   = VXL_CNT_W
) (
    input  logic [LEN_W-1:0] len_op,
    output logic [CNT_W-1:0] count
);
    logic [7:0] raw;
    logic       unused_len;

    assign raw        = len_op[FLD_LSB +: 8];
    assign unused_len = ^len_op;
    assign count      = CNT_W'(vxl_clamp(raw));

endmodule

// File: rtl/vxl_vreg.sv
module vxl_vreg
    import vxl_pkg::*;
#(
    parameter int LANES  = VXL_LANES,
    parameter int BYTE_W = VXL_BYTE_W,
    localparam int VEC_W  = LANES * BYTE_W,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic [VEC_W-1:0]  init_val,
    input  logic              wr_en,
    input  logic [LANE_W-1:0] lane,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [VEC_W-1:0]  value
);
    // Lane 0 is the most significant byte of the vector.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LO = VEC_W - BYTE_W * (g + 1);
        logic [BYTE_W-1:0] byte_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                byte_q <= '0;
            end else if (init) begin
                byte_q <= init_val[LO +: BYTE_W];
            end else if (wr_en && lane == LANE_W'(g)) begin
                byte_q <= wr_byte;
            end
        end

        assign value[LO +: BYTE_W] = byte_q;
    end

    always_comb begin
        rd_byte = '0;
        for (int k = 0; k < LANES; k++) begin
            if (lane == LANE_W'(k)) rd_byte = value[VEC_W - BYTE_W * (k + 1) +: BYTE_W];
        end
    end

endmodule

// File: rtl/vxl_seq.sv
module vxl_seq
    import vxl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = VXL_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              is_store,
    input  logic              reverse,
    input  logic [CNT_W-1:0]  count,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              mem_ack,
    output logic              accept,
    output logic              capture,
    output logic              rev_q,
    output logic [CNT_W-1:0]  step_q,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              vec_we,
    output logic              done,
    output logic              busy
);
    vxl_state_e        state_q;
    vxl_op_t           op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  step_nx;

    assign accept  = (state_q == ST_IDLE) && start;
    assign step_nx = step_q + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= '0;
            addr_q  <= '0;
            step_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        op_q.store   <= is_store;
                        op_q.reverse <= reverse;
                        op_q.count   <= count;
                        addr_q       <= addr_in;
                        step_q       <= '0;
                        state_q      <= (count == '0) ? ST_FIN : ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (mem_ack) begin
                        addr_q <= addr_q + ADDR_W'(1);
                        step_q <= step_nx;
                        if (step_nx == op_q.count) state_q <= ST_FIN;
                    end
                end
                ST_FIN:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rev_q    = op_q.reverse;
    assign mem_req  = (state_q == ST_XFER);
    assign mem_we   = mem_req && op_q.store;
    assign mem_addr = addr_q;
    assign capture  = mem_req && mem_ack && !op_q.store;
    assign done     = (state_q == ST_FIN);
    assign vec_we   = done && !op_q.store;
    assign busy     = (state_q != ST_IDLE);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))) // R9
        else $error("request dropped or changed before ack");

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> (!mem_req || mem_addr == $past(mem_addr) + ADDR_W'(1))) // R7
        else $error("address did not advance by one");

    AST_ZERO_SKIP: assert property (@(posedge clk) disable iff (rst)
        (accept && count == '0) |=> (!mem_req && done)) // R4
        else $error("zero count issued an access");

    AST_WE_DONE: assert property (@(posedge clk) disable iff (rst)
        vec_we |-> (done && !mem_req)) // R8
        else $error("vector write outside completion");

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (step_q < op_q.count && op_q.count <= CNT_W'(VXL_LANES))) // R2
        else $error("step beyond clamped count");

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(op_q) || $past(done))) // R11
        else $error("operation changed while busy");

endmodule

// File: rtl/vxl_mover.sv
module vxl_mover
    import vxl_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 is_store,
    input  logic                 le_mode,
    input  logic                 left_just,
    input  logic [ADDR_W-1:0]    addr_in,
    input  logic [VXL_LEN_W-1:0] len_op,
    input  logic [VXL_VEC_W-1:0] vec_in,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [VXL_BYTE_W-1:0] mem_wdata,
    input  logic                 mem_ack,
    input  logic [VXL_BYTE_W-1:0] mem_rdata,
    output logic [VXL_VEC_W-1:0] vec_out,
    output logic                 vec_we,
    output logic                 done,
    output logic                 busy
);
    logic [VXL_CNT_W-1:0]  count;
    logic [VXL_CNT_W-1:0]  step;
    logic [VXL_LANE_W-1:0] lane;
    logic [VXL_VEC_W-1:0]  init_val;
    logic                  accept;
    logic                  capture;
    logic                  rev_q;
    logic                  reverse;

    assign reverse  = le_mode && !left_just;
    assign init_val = is_store ? vec_in : '0;
    assign lane     = vxl_lane(step[VXL_LANE_W-1:0], rev_q);

    vxl_len_decode u_len (
        .len_op (len_op),
        .count  (count)
    );

    vxl_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .is_store (is_store),
        .reverse  (reverse),
        .count    (count),
        .addr_in  (addr_in),
        .mem_ack  (mem_ack),
        .accept   (accept),
        .capture  (capture),
        .rev_q    (rev_q),
        .step_q   (step),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .vec_we   (vec_we),
        .done     (done),
        .busy     (busy)
    );

    vxl_vreg u_vreg (
        .clk      (clk),
        .rst      (rst),
        .init     (accept),
        .init_val (init_val),
        .wr_en    (capture),
        .lane     (lane),
        .wr_byte  (mem_rdata),
        .rd_byte  (mem_wdata),
        .value    (vec_out)
    );

    AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && !mem_ack) |=> $stable(mem_wdata)) // R9
        else $error("write data changed before ack");

    AST_LOAD_ONLY_WE: assert property (@(posedge clk) disable iff (rst)
        vec_we |=> !vec_we) // R8
        else $error("vector write held for more than one cycle");

endmodule

// File: tb/vxl_mover_tb.sv
module vxl_mover_tb;
    logic         clk = 1'b0;
    logic         rst;
    logic         start, is_store, le_mode, left_just;
    logic [31:0]  addr_in;
    logic [63:0]  len_op;
    logic [127:0] vec_in;
    logic         mem_req, mem_we, mem_ack, vec_we, done, busy;
    logic [31:0]  mem_addr;
    logic [7:0]   mem_wdata, mem_rdata;
    logic [127:0] vec_out;

    always #2.5 clk = ~clk;

    vxl_mover u_dut (
        .clk(clk), .rst(rst), .start(start), .is_store(is_store), .le_mode(le_mode),
        .left_just(left_just), .addr_in(addr_in), .len_op(len_op), .vec_in(vec_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .vec_out(vec_out), .vec_we(vec_we),
        .done(done), .busy(busy)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    logic [7:0]  mem [256];
    logic [7:0]  exp_mem [256];
    int          ack_delay = 0;
    int          wait_cnt = 0;
    int          acc_cnt = 0;
    int          addr_err = 0;
    int          we_cnt = 0;
    logic [31:0] op_base = '0;

    // Byte memory with programmable ack latency; checks every address.
    always @(negedge clk) begin
        if (rst) begin
            mem_ack = 1'b0; wait_cnt = 0;
        end else if (mem_req) begin
            if (wait_cnt >= ack_delay) begin
                if (mem_addr != op_base + 32'(acc_cnt)) addr_err++;
                if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
                else        mem_rdata = mem[mem_addr[7:0]];
                mem_ack = 1'b1; wait_cnt = 0; acc_cnt++;
            end else begin
                mem_ack = 1'b0; wait_cnt++;
            end
        end else begin
            mem_ack = 1'b0;
        end
        if (vec_we) we_cnt++;
    end

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input bit st, input bit le, input bit lj, input logic [31:0] addr,
                          input logic [63:0] len, input logic [127:0] vin, input int dly,
                          input bit poke);
        int          cnt, cyc;
        bit          rev, same;
        int          lane;
        logic [127:0] exp_v;
        string       mtag;
        cnt   = (len[63:56] >= 8'd16) ? 16 : int'(len[63:56]);
        rev   = le && !lj;
        mtag  = st ? (rev ? "R10 R5" : "R10 R6") : (rev ? "R3 R5" : "R3 R6");
        exp_v = '0;
        for (int k = 0; k < 256; k++) exp_mem[k] = mem[k];
        for (int i = 0; i < cnt; i++) begin
            logic [31:0] a;
            a    = addr + 32'(i);
            lane = rev ? 15 - i : i;
            if (st) exp_mem[a[7:0]] = vin[127 - 8*lane -: 8];
            else    exp_v[127 - 8*lane -: 8] = mem[a[7:0]];
        end
        @(negedge clk);
        ack_delay = dly; acc_cnt = 0; addr_err = 0; we_cnt = 0; op_base = addr;
        is_store = st; le_mode = le; left_just = lj; addr_in = addr; len_op = len; vec_in = vin;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            @(negedge clk);
            is_store = ~st; len_op = '1; addr_in = 32'h80; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        cyc = 0;
        while (!done && cyc < 400) begin @(negedge clk); cyc++; end
        @(negedge clk);
        chk(acc_cnt == cnt, "R1 R2 access count", 128'(acc_cnt), 128'(cnt));
        chk(addr_err == 0, "R7 address sequence", 128'(addr_err), 128'd0);
        if (st) begin
            same = 1'b1;
            for (int k = 0; k < 256; k++) if (mem[k] !== exp_mem[k]) same = 1'b0;
            chk(same, mtag, 128'(same), 128'd1);
            chk(we_cnt == 0, "R8 no vec_we on store", 128'(we_cnt), 128'd0);
        end else begin
            chk(vec_out === exp_v, mtag, vec_out, exp_v);
            chk(we_cnt == 1, "R8 single vec_we", 128'(we_cnt), 128'd1);
        end
        if (poke) begin
            same = 1'b1;
            for (int k = 0; k < 256; k++) if (mem[k] !== exp_mem[k]) same = 1'b0;
            chk(same, "R11 no stray store", 128'(same), 128'd1);
        end
    endtask

    // {store, le, left_just, addr[31:0], count field[7:0], ack delay[1:0]}
    localparam int NV = 12;
    localparam logic [44:0] TBL [NV] = '{
        {3'b000, 32'h0000_0010, 8'd5,    2'd0},
        {3'b010, 32'h0000_0020, 8'd7,    2'd0},
        {3'b011, 32'h0000_0030, 8'd9,    2'd1},
        {3'b000, 32'h0000_0041, 8'd16,   2'd0},
        {3'b010, 32'h0000_0055, 8'h40,   2'd0},
        {3'b001, 32'h0000_0060, 8'hFF,   2'd2},
        {3'b100, 32'h0000_0090, 8'd3,    2'd0},
        {3'b110, 32'h0000_00A0, 8'd11,   2'd1},
        {3'b100, 32'h0000_00C0, 8'h90,   2'd0},
        {3'b000, 32'hFFFF_FFFC, 8'd8,    2'd1},
        {3'b111, 32'hFFFF_FFFE, 8'd4,    2'd2},
        {3'b010, 32'h0000_0007, 8'd1,    2'd0}
    };

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 256; k++) mem[k] = 8'(k * 37 + 11);
        rst = 1'b1; start = 1'b0; is_store = 1'b0; le_mode = 1'b0; left_just = 1'b0;
        addr_in = '0; len_op = '0; vec_in = '0; mem_rdata = '0; mem_ack = 1'b0;
        repeat (3) @(negedge clk);
        // Reset state (R8, R9)
        chk({mem_req, vec_we, done, busy} == 4'b0, "R9 R8 reset outputs",
            128'({mem_req, vec_we, done, busy}), 128'd0);
        chk(vec_out == '0, "R8 reset vec_out", vec_out, 128'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            logic [44:0] e;
            logic [127:0] pat;
            e   = TBL[v];
            pat = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0 ^ {16{8'(v * 17)}};
            // Low 56 bits of the length carry junk: R1
            run_op(e[44], e[43], e[42], e[41:10], {e[9:2], 56'hA5_5A3C_C3F0_0F99}, pat,
                   int'(e[1:0]), 1'b0);
        end

        // R4: zero count load after a nonzero result clears vec_out
        run_op(1'b0, 1'b0, 1'b0, 32'h10, 64'h00FF_FFFF_FFFF_FFFF, '0, 0, 1'b0);
        // R4: zero count store performs no writes
        run_op(1'b1, 1'b1, 1'b0, 32'h20, 64'h0012_3456_789A_BCDE, '1, 0, 1'b0);
        // R11: stray start during a slow load
        run_op(1'b0, 1'b1, 1'b0, 32'h33, {8'd12, 56'h0}, '0, 2, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule